// File: doc/BRIEF.md
# Glitch-free protected power-of-two clock prescaler

This block turns an undivided input clock into a slower core clock by an integer power-of-two factor between 1 and 256. The factor comes from a small control register that sits on a single-cycle register-write bus. Software cannot change that register with one write. It first writes an unlock pattern and then, within a short window of input-clock cycles, writes the new divide code. Any other sequence leaves the setting as it was.

The gated core clock moves to a new rate only at a period boundary of the old rate. It therefore never emits a runt pulse, and it never runs faster than the faster of the two settings. The counter behind the division runs on the input clock and is not visible on the bus. A static enable routes the core clock onto a clock-output pin, and that pin keeps toggling while reset is held.

Top module: `pwr2_clk_prescaler`

## Requirements
- R1: In steady state, consecutive rising edges of `core_clk` are 2^k input-clock periods apart. k is the divide code (0 to 8) held in `rd_data[3:0]`.
- R2: A write of exactly 0x80 (bit 7 set, bits 6:0 clear) opens the unlock window. A write made while the window is closed never changes the divide code, and that includes a write with bit 7 and other bits set.
- R3: An update write has bit 7 clear and the code in bits 3:0. It is accepted when it lands on one of the four input-clock edges that follow the unlock edge. From the fifth edge on, the window has expired and the update is dropped.
- R4: `rd_data[7]` reads 1 only while the unlock window is open, and it reads 0 once the window is closed by acceptance, rejection or expiry. `rd_data[3:0]` shows the committed code, and bits 6:4 read 0.
- R5: An update write that carries a reserved code (9 to 15) leaves the divide code unchanged and closes the window.
- R6: During a rate switch, every interval between `core_clk` rising edges equals either the old period or the new period. The old-length intervals all come before the new-length ones.
- R7: After the accepting edge, the first interval of the new length completes within T1+2·T2 input periods, where T1 is the old period and T2 is the new one. The next interval also has the new length.
- R8: After reset is released, the divide code equals `cfg_div_sel`. A reserved value on `cfg_div_sel` loads code 0.
- R9: While `rst_n` is low and `cko_en` is high, `clk_pin` toggles at the input-clock rate.
- R10: While `cko_en` is low, `clk_pin` stays low and `core_clk` keeps running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_in | input | 1 | Undivided input clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| cfg_div_sel | input | 4 | Divide code loaded when reset is released |
| cko_en | input | 1 | Static enable that routes the core clock onto `clk_pin` |
| wr_en | input | 1 | Register-write strobe, sampled on `clk_in` |
| wr_data | input | 8 | Write data: bit 7 is change-enable, bits 3:0 are the divide code |
| rd_data | output | 8 | Readback: bit 7 is window open, bits 3:0 are the committed code |
| core_clk | output | 1 | Divided, gated core clock |
| clk_pin | output | 1 | Core clock driven on the clock-output pin when enabled |

## Verification
The bench builds the block with its default parameters: a 4-bit code with codes up to 8, a four-cycle unlock window and an 8-bit data bus. With these values the whole range from divide-by-1 to divide-by-256 can be reached, as can the exact last and first-too-late cycles of the window and the reserved codes 9 to 15. Random update attempts vary the code and the unlock-to-update delay. Each switch is timed edge by edge against the old and new periods, so that runt intervals, intermediate rates and the T1+2·T2 bound can all be observed.

// File: rtl/clkpre_pkg.sv
`timescale 1ns/1ps
package clkpre_pkg;
  // Unlock sequencer states
  typedef enum logic [0:0] {
    UL_IDLE  = 1'b0,
    UL_ARMED = 1'b1
  } ul_state_e;
endpackage

// File: rtl/clkpre_rst_sync.sv
`timescale 1ns/1ps
module clkpre_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n_sync
);
  logic [STAGES-1:0] chain_q;

  // Bit 0 takes a constant 1 on every clock.
  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) chain_q[0] <= 1'b0;
    else         chain_q[0] <= 1'b1;
  end

  // The remaining stages shift that 1 along the chain.
  for (genvar g = 1; g < STAGES; g++) begin : g_stage
    always_ff @(posedge clk or negedge arst_n) begin
      if (!arst_n) chain_q[g] <= 1'b0;
      else         chain_q[g] <= chain_q[g-1];
    end
  end

  assign rst_n_sync = chain_q[STAGES-1];
endmodule

// File: rtl/clkpre_unlock.sv
`timescale 1ns/1ps
module clkpre_unlock
  import clkpre_pkg::*;
#(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 8,
  parameter int WIN_CYC = 4,
  parameter int DATA_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_sel,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [SEL_W-1:0]  sel_o,
  output logic              win_open_o
);
  localparam int               WIN_W    = $clog2(WIN_CYC + 1);
  localparam int               CE_POS   = DATA_W - 1;
  localparam logic [SEL_W-1:0] MAX_CODE = SEL_W'(MAX_SEL);
  localparam logic [DATA_W-1:0] UNLOCK_PAT = {1'b1, {(DATA_W-1){1'b0}}};

  ul_state_e        st_q, st_d;
  logic [WIN_W-1:0] win_q, win_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic             init_q, init_d;

  logic             is_unlock, is_update, code_ok;
  logic [SEL_W-1:0] wr_code, cfg_clamped;

  always_comb begin
    is_unlock   = wr_en && (wr_data == UNLOCK_PAT);
    is_update   = wr_en && !wr_data[CE_POS] && (st_q == UL_ARMED);
    wr_code     = wr_data[SEL_W-1:0];
    code_ok     = (wr_code <= MAX_CODE);
    cfg_clamped = (cfg_sel > MAX_CODE) ? '0 : cfg_sel;
  end

  // Next-state logic
  always_comb begin
    st_d   = st_q;
    win_d  = win_q;
    sel_d  = sel_q;
    init_d = init_q;
    // The window counts down on its own.
    if (win_q != '0) win_d = win_q - WIN_W'(1);
    if (win_d == '0) st_d = UL_IDLE;
    if (!init_q) begin
      sel_d  = cfg_clamped;
      init_d = 1'b1;
    end else if (is_unlock) begin
      st_d  = UL_ARMED;
      win_d = WIN_W'(WIN_CYC);
    end else if (is_update) begin
      if (code_ok) sel_d = wr_code;
      st_d  = UL_IDLE;
      win_d = '0;
    end else if (wr_en) begin
      // Any other write disarms the sequencer.
      st_d  = UL_IDLE;
      win_d = '0;
    end
  end

  // State registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= UL_IDLE;
      win_q  <= '0;
      sel_q  <= '0;
      init_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      win_q  <= win_d;
      sel_q  <= sel_d;
      init_q <= init_d;
    end
  end

  assign sel_o      = sel_q;
  assign win_open_o = (st_q == UL_ARMED);

  AST_LOCKED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && !(wr_en && st_q == UL_ARMED)) |=> $stable(sel_q)); // R2
  AST_RESERVED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (init_q && wr_en && !wr_data[CE_POS] && (wr_data[SEL_W-1:0] > MAX_CODE)) |=> $stable(sel_q)); // R5
  AST_WIN_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == UL_ARMED && win_q == WIN_W'(1) && !wr_en) |=> (st_q == UL_IDLE)); // R3
endmodule

// File: rtl/clkpre_divider.sv
`timescale 1ns/1ps
module clkpre_divider #(
  parameter int SEL_W   = 4,
  parameter int MAX_SEL = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] tgt_sel,
  output logic             pulse_req
);
  localparam int CNT_W = (MAX_SEL < 1) ? 1 : MAX_SEL;

  // Terminal count for a given code: 2^code - 1
  function automatic logic [CNT_W-1:0] lim_of(input logic [SEL_W-1:0] c);
    logic [CNT_W:0] p;
    p = (CNT_W+1)'(1) << c;
    return CNT_W'(p - (CNT_W+1)'(1));
  endfunction

  logic [CNT_W-1:0] cnt_q, cnt_d, cur_lim;
  logic [SEL_W-1:0] cur_q, cur_d;
  logic             wrap;

  always_comb begin
    cur_lim = lim_of(cur_q);
    wrap    = (cnt_q == cur_lim);
    cnt_d   = cnt_q + CNT_W'(1);
    cur_d   = cur_q;
    if (wrap) begin
      // A pending code is taken only at a period boundary.
      cnt_d = '0;
      cur_d = tgt_sel;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      cur_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      cur_q <= cur_d;
    end
  end

  assign pulse_req = (cnt_q == '0);

  AST_CNT_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= cur_lim); // R1
  AST_SWAP_ON_RESTART: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q != '0) |-> $stable(cur_q)); // R6
endmodule

// File: rtl/clkpre_gate.sv
`timescale 1ns/1ps
module clkpre_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic en_in,
  output logic gclk
);
  logic en_q;

  // Enable captured while clk is low, so the AND never forms a partial pulse.
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) en_q <= 1'b1;
    else        en_q <= en_in;
  end

  assign gclk = clk & en_q;
endmodule

// File: rtl/pwr2_clk_prescaler.sv
`timescale 1ns/1ps
module pwr2_clk_prescaler #(
  parameter int SEL_W       = 4,
  parameter int MAX_SEL     = 8,
  parameter int WIN_CYC     = 4,
  parameter int DATA_W      = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk_in,
  input  logic              rst_n,
  input  logic [SEL_W-1:0]  cfg_div_sel,
  input  logic              cko_en,
  input  logic              wr_en,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] rd_data,
  output logic              core_clk,
  output logic              clk_pin
);
  logic             rst_sync_n;
  logic [SEL_W-1:0] sel;
  logic             win_open;
  logic             pulse_req;

  clkpre_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk_in),
    .arst_n     (rst_n),
    .rst_n_sync (rst_sync_n)
  );

  clkpre_unlock #(
    .SEL_W(SEL_W), .MAX_SEL(MAX_SEL), .WIN_CYC(WIN_CYC), .DATA_W(DATA_W)
  ) u_unlock (
    .clk        (clk_in),
    .rst_n      (rst_sync_n),
    .cfg_sel    (cfg_div_sel),
    .wr_en      (wr_en),
    .wr_data    (wr_data),
    .sel_o      (sel),
    .win_open_o (win_open)
  );

  clkpre_divider #(.SEL_W(SEL_W), .MAX_SEL(MAX_SEL)) u_div (
    .clk       (clk_in),
    .rst_n     (rst_sync_n),
    .tgt_sel   (sel),
    .pulse_req (pulse_req)
  );

  clkpre_gate u_gate (
    .clk   (clk_in),
    .rst_n (rst_sync_n),
    .en_in (pulse_req),
    .gclk  (core_clk)
  );

  always_comb begin
    rd_data             = '0;
    rd_data[SEL_W-1:0]  = sel;
    rd_data[DATA_W-1]   = win_open;
  end

  assign clk_pin = core_clk & cko_en;
endmodule

// File: tb/tb_pwr2_clk_prescaler.sv
`timescale 1ns/1ps
module tb_pwr2_clk_prescaler;
  localparam int MASK = 4095;

  logic       clk_in = 1'b0;
  logic       rst_n;
  logic [3:0] cfg_div_sel;
  logic       cko_en;
  logic       wr_en;
  logic [7:0] wr_data;
  logic [7:0] rd_data;
  logic       core_clk, clk_pin;

  int    n_chk = 0, n_fail = 0;
  bit    done = 0;
  int    exp_sel;
  longint edge_t [0:MASK];
  int    edge_n = 0;
  int    pin_rises = 0;

  always #5 clk_in = ~clk_in;

  pwr2_clk_prescaler dut (
    .clk_in(clk_in), .rst_n(rst_n), .cfg_div_sel(cfg_div_sel), .cko_en(cko_en),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
    .core_clk(core_clk), .clk_pin(clk_pin)
  );

  always @(posedge core_clk) begin
    edge_t[edge_n & MASK] = $time;
    edge_n = edge_n + 1;
  end
  always @(posedge clk_pin) pin_rises = pin_rises + 1;

  task automatic chk(input bit ok, input string req, input longint act, input longint expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  function automatic longint ivl(input int m);
    return edge_t[m & MASK] - edge_t[(m-1) & MASK];
  endfunction

  task automatic drive_cycle(input logic en, input logic [7:0] d,
                             output logic [7:0] rd_seen, output longint t_edge);
    @(negedge clk_in);
    rd_seen = rd_data;
    wr_en   = en;
    wr_data = d;
    @(posedge clk_in);
    t_edge = $time;
  endtask

  task automatic check_steady(input int n, input string req);
    int base;
    base = edge_n;
    while (edge_n < base + 3) @(negedge clk_in);
    chk(ivl(edge_n - 1) == n*10, req, ivl(edge_n - 1), n*10);
  endtask

  task automatic switch_check(input int n1, input int n2, input longint t_acc);
    int i, m;
    while ($time < t_acc + longint'(n1 + 3*n2 + 4) * 10) @(negedge clk_in);
    i = edge_n - 1;
    while (i > 0 && edge_t[(i-1) & MASK] > t_acc) i--;
    m = i;
    if (n1 != n2)
      while (m < edge_n - 2 && ivl(m) == n1*10) m++;
    chk(ivl(m) == n2*10, "R6 interval after old-length run", ivl(m), n2*10);
    chk(edge_t[m & MASK] - t_acc <= longint'(n1 + 2*n2) * 10, "R7 latency",
        edge_t[m & MASK] - t_acc, longint'(n1 + 2*n2) * 10);
    chk(ivl(m+1) == n2*10, "R7 settled interval", ivl(m+1), n2*10);
  endtask

  // Unlock, then send an update on the d-th edge after the unlock edge.
  task automatic attempt(input logic [3:0] code, input int d);
    logic [7:0] rd;
    longint t, t_acc;
    int old_sel;
    bit acc;
    old_sel = exp_sel;
    drive_cycle(1'b1, 8'h80, rd, t);
    for (int s = 1; s <= d; s++) begin
      drive_cycle(s == d, (s == d) ? {4'h0, code} : 8'h00, rd, t);
      if (s == 1) chk(rd[7] == 1'b1, "R4 window flag after unlock", rd[7], 1);
      if (s == d) begin
        chk(rd[7] == (d <= 4), "R3 window open at update edge", rd[7], (d <= 4));
        t_acc = t;
      end
    end
    acc = (d <= 4) && (code <= 4'd8);
    if (acc) exp_sel = code;
    drive_cycle(1'b0, 8'h00, rd, t);
    chk(rd == {4'h0, 4'(exp_sel)}, (code > 8) ? "R5 reserved code readback" :
        "R3 readback after attempt", rd, {4'h0, 4'(exp_sel)});
    if (acc) switch_check(1 << old_sel, 1 << exp_sel, t_acc);
    else     check_steady(1 << old_sel, "R1 period kept after rejected update");
  endtask

  initial begin
    #(200000 * 10);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    logic [7:0] rd;
    longint t;
    int p0, e0;
    void'($urandom(32'd4711));
    rst_n = 1'b0; cfg_div_sel = 4'd3; cko_en = 1'b1; wr_en = 1'b0; wr_data = 8'h00;

    // R9: pin follows the input clock while reset is held
    repeat (3) @(negedge clk_in);
    p0 = pin_rises;
    repeat (16) @(negedge clk_in);
    chk(pin_rises - p0 == 16, "R9 pin rises during reset", pin_rises - p0, 16);

    rst_n = 1'b1;
    repeat (20) @(negedge clk_in);
    chk(rd_data == 8'h03, "R8 reset loads cfg code", rd_data, 8'h03);
    exp_sel = 3;
    check_steady(8, "R1 divide by 8 after reset");

    // R2: writes without unlock
    drive_cycle(1'b1, 8'h05, rd, t);
    drive_cycle(1'b0, 8'h00, rd, t);
    drive_cycle(1'b0, 8'h00, rd, t);
    chk(rd == 8'h03, "R2 locked write ignored", rd, 8'h03);
    drive_cycle(1'b1, 8'h81, rd, t);
    drive_cycle(1'b0, 8'h00, rd, t);
    chk(rd[7] == 1'b0, "R2 bad unlock pattern keeps window shut", rd[7], 0);
    drive_cycle(1'b1, 8'h05, rd, t);
    drive_cycle(1'b0, 8'h00, rd, t);
    chk(rd == 8'h03, "R2 update after bad unlock ignored", rd, 8'h03);
    check_steady(8, "R1 period unchanged after locked writes");

    // Directed window and code corners
    attempt(4'd10, 2);  // R5 reserved
    attempt(4'd15, 1);  // R5 reserved
    attempt(4'd1, 5);   // R3 first late edge
    attempt(4'd0, 4);   // R3 last edge in window, switch to divide by 1
    attempt(4'd8, 1);   // R1 divide by 1 to 256
    attempt(4'd0, 3);   // 256 back to 1
    attempt(4'd2, 2);

    // R10: pin held low when not enabled
    cko_en = 1'b0;
    @(negedge clk_in);
    p0 = pin_rises; e0 = edge_n;
    repeat (20) @(negedge clk_in);
    chk(pin_rises == p0, "R10 pin quiet when disabled", pin_rises - p0, 0);
    chk(edge_n - e0 == 5, "R10 core clock still runs", edge_n - e0, 5);
    cko_en = 1'b1;

    // Constrained random attempts
    for (int it = 0; it < 30; it++) begin
      int r, dd;
      logic [3:0] c;
      r  = $urandom;
      c  = (r % 5 == 0) ? 4'(9 + (r / 5) % 7) : 4'((r / 7) % 9);
      dd = 1 + ($urandom % 6);
      attempt(c, dd);
    end

    // R8: reserved cfg value loads code 0
    rst_n = 1'b0; cfg_div_sel = 4'd12;
    repeat (4) @(negedge clk_in);
    rst_n = 1'b1;
    repeat (10) @(negedge clk_in);
    chk(rd_data == 8'h00, "R8 reserved cfg loads code 0", rd_data, 8'h00);
    exp_sel = 0;
    check_steady(1, "R1 divide by 1 after reserved cfg");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
    $finish;
  end
endmodule